// File: doc/BRIEF.md
# Streaming dual-clock FIFO synchronizer

This block carries a stream of 18-bit samples from a fast source clock (around 400 MHz) into a slower destination clock (around 100 MHz). The source presents a sample together with a valid strobe on any cycle and never waits. Each accepted sample is written into a 16-entry memory on the source clock and read out of it on the destination clock. The samples themselves never pass through a synchronizer.

Only the write and read pointers cross between the domains. Each pointer is kept in Gray code in a register in its own domain, so exactly one bit changes per step. Each is then passed through a two-flop synchronizer in the other domain.

The destination side reads whenever the memory holds data. Each read gives one destination cycle with the valid output high and the sample on the data output. A sample that arrives while all 16 entries are occupied is discarded, and the overrun output pulses for one source cycle. A single asynchronous reset input clears both domains, and each domain releases it on its own clock.

Top module: `stream_cdc_fifo`

## Requirements
- R1: While reset is asserted, and after its release until a sample is written, `dst_valid` and `overrun` are 0.
- R2: Every accepted 18-bit sample appears on `dst_data` bit-exact and in arrival order.
- R3: Each delivered sample gives exactly one destination cycle with `dst_valid` high, and `dst_data` holds that sample during that cycle; `dst_valid` is never high without a sample behind it.
- R4: Consecutive samples that invert all 18 bits (0x00000, 0x3FFFF, 0x00000, ...) arrive with no intermediate or mixed words.
- R5: A stream with one sample every four source cycles (the destination rate) passes with no loss and no `overrun` pulse.
- R6: After the source stops, every stored sample is delivered and `dst_valid` then stays 0.
- R7: A sample presented while the FIFO is full is dropped, and `overrun` is high for one source cycle per dropped sample, one cycle after that sample. Stored samples are not altered, so the delivered samples are an in-order subset of those sent, and delivered plus dropped equals sent.
- R8: The write and read pointers that cross domains are Gray-coded: each change of either register flips exactly one bit.
- R9: A reset asserted in the middle of a stream leaves the FIFO empty with no stale sample delivered afterwards, and later passthrough is correct.
- R10: Up to 16 unread samples are held, so the first 16 samples of a burst presented to an empty FIFO are always delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock |
| dst_clk | input | 1 | Destination-domain clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| src_data | input | 18 | Sample from the source |
| src_valid | input | 1 | Sample strobe; the source does not wait |
| dst_data | output | 18 | Sample delivered in the destination domain |
| dst_valid | output | 1 | High for one destination cycle per delivered sample |
| overrun | output | 1 | One source-cycle pulse per dropped sample |

## Verification
Most internal faults show up at the output within a few destination cycles.
- A wrong pointer comparison or a broken synchronizer makes `dst_valid` rise with no sample queued, or delivers a word that differs from the scoreboard's next entry.
- A wrong full test shows up during the sustained burst, either as surplus `overrun` pulses or as samples out of order.
- A pointer that is not cleared by reset shows up as stale words after the mid-stream reset, within about four destination cycles of its release.
- A mixed word on the all-bits-flip pattern fails the very next comparison.

// File: rtl/stream_cdc_fifo.sv
module stream_cdc_fifo #(
  parameter int WIDTH = 18,
  parameter int AW    = 4,
  parameter int SYNC  = 2
) (
  input  logic             src_clk,
  input  logic             dst_clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] src_data,
  input  logic             src_valid,
  output logic [WIDTH-1:0] dst_data,
  output logic             dst_valid,
  output logic             overrun
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [SYNC-1:0] src_rs, dst_rs;
  logic src_rst_n, dst_rst_n;

  always_ff @(posedge src_clk or negedge arst_n)
    if (!arst_n) src_rs <= '0;
    else         src_rs <= {src_rs[SYNC-2:0], 1'b1};

  always_ff @(posedge dst_clk or negedge arst_n)
    if (!arst_n) dst_rs <= '0;
    else         dst_rs <= {dst_rs[SYNC-2:0], 1'b1};

  assign src_rst_n = src_rs[SYNC-1];
  assign dst_rst_n = dst_rs[SYNC-1];

  logic [WIDTH-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [SYNC-1:0][PW-1:0] rq_s, wq_s;
  logic [PW-1:0] rq, wq, wbin_nx, rbin_nx;
  logic full, empty, push, pop;

  always_ff @(posedge src_clk or negedge arst_n)
    if (!arst_n) rq_s <= '0;
    else         rq_s <= {rq_s[SYNC-2:0], rgray};

  always_ff @(posedge dst_clk or negedge arst_n)
    if (!arst_n) wq_s <= '0;
    else         wq_s <= {wq_s[SYNC-2:0], wgray};

  assign rq = rq_s[SYNC-1];
  assign wq = wq_s[SYNC-1];

  assign wbin_nx = wbin + 1'b1;
  assign full    = (wgray == {~rq[PW-1:PW-2], rq[PW-3:0]});
  assign push    = src_valid && !full && src_rst_n;

  always_ff @(posedge src_clk or negedge arst_n)
    if (!arst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      overrun <= 1'b0;
    end else if (!src_rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= src_valid && full;
      if (push) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end

  always_ff @(posedge src_clk)
    if (push) mem[wbin[AW-1:0]] <= src_data;

  assign rbin_nx = rbin + 1'b1;
  assign empty   = (rgray == wq);
  assign pop     = !empty && dst_rst_n;

  always_ff @(posedge dst_clk or negedge arst_n)
    if (!arst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      dst_valid <= 1'b0;
      dst_data  <= '0;
    end else if (!dst_rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      dst_valid <= 1'b0;
    end else begin
      dst_valid <= pop;
      if (pop) begin
        dst_data <= mem[rbin[AW-1:0]];
        rbin     <= rbin_nx;
        rgray    <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
endmodule

// File: rtl/stream_cdc_fifo_chk.sv
module stream_cdc_fifo_chk #(
  parameter int PW = 5
) (
  input logic          src_clk,
  input logic          dst_clk,
  input logic          src_rst_n,
  input logic          dst_rst_n,
  input logic          src_valid,
  input logic          full,
  input logic          empty,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic          overrun,
  input logic          dst_valid
);
  p_wgray_step_r8: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (wgray != $past(wgray)) |-> ($countones(wgray ^ $past(wgray)) == 1));

  p_rgray_step_r8: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (rgray != $past(rgray)) |-> ($countones(rgray ^ $past(rgray)) == 1));

  p_drop_when_full_r7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_valid && full) |=> (overrun && $stable(wgray)));

  p_overrun_cause_r7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(overrun) |-> $past(src_valid && full));

  p_no_read_empty_r6: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    empty |=> $stable(rgray));

  p_valid_has_data_r3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $rose(dst_valid) |-> $past(!empty));
endmodule

bind stream_cdc_fifo stream_cdc_fifo_chk #(.PW(AW + 1)) u_chk (
  .src_clk  (src_clk),
  .dst_clk  (dst_clk),
  .src_rst_n(src_rst_n),
  .dst_rst_n(dst_rst_n),
  .src_valid(src_valid),
  .full     (full),
  .empty    (empty),
  .wgray    (wgray),
  .rgray    (rgray),
  .overrun  (overrun),
  .dst_valid(dst_valid)
);

// File: tb/stream_cdc_fifo_tb.sv
`timescale 1ns/1ps
module stream_cdc_fifo_tb;
  localparam real SRC_PERIOD = 2.5;
  localparam real DST_PERIOD = 10.0;

  logic src_clk = 1'b0, dst_clk = 1'b0, arst_n = 1'b1;
  logic [17:0] src_data = '0;
  logic src_valid = 1'b0;
  logic [17:0] dst_data;
  logic dst_valid, overrun;

  stream_cdc_fifo u_dut (
    .src_clk(src_clk), .dst_clk(dst_clk), .arst_n(arst_n),
    .src_data(src_data), .src_valid(src_valid),
    .dst_data(dst_data), .dst_valid(dst_valid), .overrun(overrun)
  );

  always #(SRC_PERIOD/2) src_clk = ~src_clk;
  always #(DST_PERIOD/2) dst_clk = ~dst_clk;

  int total = 0, bad = 0;
  int mode = 2;
  string cur_req = "R1";
  logic [17:0] exp_q[$];
  logic [17:0] rx_q[$];
  int ovr_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge src_clk) if (overrun) ovr_cnt++;

  always @(negedge dst_clk) begin
    if (dst_valid) begin
      if (mode == 0) begin
        if (exp_q.size() == 0) check(0, "R3 valid without sample", int'(dst_data), 0);
        else begin
          automatic logic [17:0] e = exp_q.pop_front();
          check(dst_data == e, cur_req, int'(dst_data), int'(e));
        end
      end else if (mode == 1) rx_q.push_back(dst_data);
      else check(0, cur_req, int'(dst_data), 0);
    end
  end

  task automatic send(input logic [17:0] v, input int gap);
    src_data  = v;
    src_valid = 1'b1;
    if (mode == 0) exp_q.push_back(v);
    @(negedge src_clk);
    src_valid = 1'b0;
    repeat (gap - 1) @(negedge src_clk);
  endtask

  task automatic wait_dst(input int n);
    repeat (n) @(negedge dst_clk);
  endtask

  initial begin
    repeat (150000) @(posedge dst_clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 arst_n = 1'b0;
    wait_dst(4);
    check(dst_valid == 1'b0, "R1 dst_valid in reset", int'(dst_valid), 0);
    check(overrun == 1'b0, "R1 overrun in reset", int'(overrun), 0);
    @(negedge src_clk) arst_n = 1'b1;
    cur_req = "R1 valid after reset with no input";
    wait_dst(12);
    check(dst_valid == 1'b0 && ovr_cnt == 0, "R1 idle after release", ovr_cnt, 0);

    mode = 0;
    cur_req = "R2 single sample";
    @(negedge src_clk);
    send(18'h12345, 4);
    wait_dst(12);
    check(exp_q.size() == 0, "R2/R3 single sample delivered once", exp_q.size(), 0);

    cur_req = "R4 all-bit flips";
    for (int i = 0; i < 16; i++) send((i % 2) ? 18'h3FFFF : 18'h00000, 4);
    for (int i = 0; i < 8; i++) send((i % 2) ? 18'h3FFFF : 18'h00000, 1);
    wait_dst(20);
    check(exp_q.size() == 0, "R4 flip stream complete", exp_q.size(), 0);

    cur_req = "R5 matched rate stream";
    ovr_cnt = 0;
    for (int i = 0; i < 300; i++) send(18'((i * 7919 + 13) & 18'h3FFFF), 4);
    wait_dst(20);
    check(ovr_cnt == 0, "R5 no overrun at matched rate", ovr_cnt, 0);
    check(exp_q.size() == 0, "R5 no loss", exp_q.size(), 0);

    cur_req = "R6 valid after drain";
    mode = 2;
    wait_dst(30);
    check(dst_valid == 1'b0, "R6 valid low after drain", int'(dst_valid), 0);

    mode = 1;
    rx_q.delete();
    ovr_cnt = 0;
    for (int i = 0; i < 48; i++) send(18'h100 + 18'(i), 1);
    wait_dst(40);
    check(rx_q.size() + ovr_cnt == 48, "R7 delivered plus dropped", rx_q.size() + ovr_cnt, 48);
    check(ovr_cnt > 0, "R7 overrun seen in burst", ovr_cnt, 1);
    for (int i = 1; i < rx_q.size(); i++)
      check(rx_q[i] > rx_q[i-1], "R7 survivors in order", int'(rx_q[i]), int'(rx_q[i-1]) + 1);
    for (int i = 0; i < 16; i++)
      check(rx_q.size() > i && rx_q[i] == 18'h100 + 18'(i), "R10 first sixteen kept",
            (rx_q.size() > i) ? int'(rx_q[i]) : -1, 'h100 + i);

    mode = 1;
    for (int i = 0; i < 10; i++) send(18'h2A000 + 18'(i), 4);
    for (int i = 0; i < 6; i++) send(18'h2B000 + 18'(i), 1);
    arst_n = 1'b0;
    mode = 2;
    cur_req = "R9 stale data after mid-stream reset";
    repeat (20) @(negedge src_clk);
    arst_n = 1'b1;
    wait_dst(20);
    check(dst_valid == 1'b0, "R9 empty after reset", int'(dst_valid), 0);

    mode = 0;
    cur_req = "R9 passthrough after reset";
    @(negedge src_clk);
    for (int i = 0; i < 20; i++) send(18'h15555 ^ 18'(i * 3), 4);
    wait_dst(20);
    check(exp_q.size() == 0, "R9 resumed stream complete", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule